// File: doc/BRIEF.md
# Dual Frame Buffer Fetch Sequencer

This block issues burst read requests to a memory read port so that a display FIFO is filled with pixel data. Two frame regions are held as a start address and a last-byte address each. With the two-region option on, every finished region hands fetching over to the other one, so software can rewrite the idle region while the active one streams out. An optional colour-table phase fetches a small table region ahead of the pixel data. The table size follows the pixel depth: 16 entries of two bytes at 4 bits per pixel, 256 entries of two bytes at 8 bits per pixel.

Each request presents a word-aligned byte address and a length in 32-bit words. The request is held until the memory grants it, and a granted burst counts as complete. One-cycle strobes report the end of each frame region, the end of the colour-table phase, and a FIFO underflow.

Top module: `dfb_fetch_seq`

## Requirements
- R1: After reset, mem_req, frame_done0, frame_done1, table_done and underflow are all low.
- R2: The burst-size code sets the burst length in words: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 4 to 7 give 16. The code is sampled when a region starts. A request stays high with a stable address and length until mem_gnt is seen high at a clock edge.
- R3: No burst reaches past the region's last byte. The final burst of a region is shortened so that it ends exactly on the last word.
- R4: With dual_en low every pass fetches region 0. With dual_en high passes alternate 0, 1, 0, 1. Completing region 0 pulses frame_done0 and completing region 1 pulses frame_done1, one cycle after the final grant.
- R5: With load_mode 0 a colour-table pass runs first, from tbl_base to tbl_base+31 (tbl_8bpp low) or tbl_base+511 (tbl_8bpp high). table_done then pulses once and pixel fetching starts at region 0.
- R6: With load_mode 1 only the colour table is fetched. After table_done no request is issued until scan_en has been low.
- R7: With load_mode 2 or 3 the colour table is skipped and the first request is at region 0's start address.
- R8: A region's start or last address changed while that region is being fetched is used only from that region's next pass.
- R9: When scan_en drops, a request already raised is held until granted. No further request follows while scan_en stays low.
- R10: underflow pulses in the cycle after pix_req and fifo_empty are both high while pixel data is being fetched. It stays low during the colour-table phase and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Starts and keeps fetching while high |
| dual_en | input | 1 | Alternate between the two frame regions |
| burst_code | input | 3 | Burst size code |
| load_mode | input | 2 | 0 table then pixels, 1 table only, 2/3 pixels only |
| tbl_8bpp | input | 1 | Colour table has 256 entries (else 16) |
| tbl_base | input | AW | Colour table start byte address |
| fb0_start | input | AW | Region 0 start byte address |
| fb0_last | input | AW | Region 0 last byte address |
| fb1_start | input | AW | Region 1 start byte address |
| fb1_last | input | AW | Region 1 last byte address |
| mem_gnt | input | 1 | Memory accepts the pending request |
| pix_req | input | 1 | Display pulls a pixel word |
| fifo_empty | input | 1 | Display FIFO has no data |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | AW | Burst start byte address |
| mem_len | output | LW | Burst length in words |
| frame_done0 | output | 1 | Region 0 completed strobe |
| frame_done1 | output | 1 | Region 1 completed strobe |
| table_done | output | 1 | Colour table completed strobe |
| underflow | output | 1 | FIFO underflow strobe |

## Verification
The bench uses several region sizes against several burst codes. Some sizes are an exact multiple of the burst and some are not, which separates correct final-burst shortening from overrun or a dropped tail. Single and dual passes are run to check the alternation order. Each load mode is run with both table sizes, so the phase ordering and the table extent are each checked on their own. Grant patterns with gaps and a grant held low while scan_en drops show whether a pending request is kept or lost, and a mid-pass address rewrite shows when new addresses take effect.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TBL  = 2'd1,
        PH_PIX  = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    localparam logic [1:0] LM_TBL_ONLY = 2'd1;

    function automatic logic [4:0] burst_words(input logic [2:0] code);
        case (code)
            3'd0:    burst_words = 5'd1;
            3'd1:    burst_words = 5'd2;
            3'd2:    burst_words = 5'd4;
            3'd3:    burst_words = 5'd8;
            default: burst_words = 5'd16;
        endcase
    endfunction

    function automatic logic [9:0] table_span(input logic wide);
        table_span = wide ? 10'd511 : 10'd31;
    endfunction

endpackage

// File: rtl/fseq_region_mux.sv
module fseq_region_mux
    import fseq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          pick_tbl,
    input  logic          pick_fb1,
    input  logic          tbl_8bpp,
    input  logic [AW-1:0] tbl_base,
    input  logic [AW-1:0] fb0_start,
    input  logic [AW-1:0] fb0_last,
    input  logic [AW-1:0] fb1_start,
    input  logic [AW-1:0] fb1_last,
    output logic [AW-1:0] reg_start,
    output logic [AW-1:0] reg_last
);
    logic [AW-1:0] span;

    always_comb begin
        span = {{(AW-10){1'b0}}, table_span(tbl_8bpp)};
        if (pick_tbl) begin
            reg_start = tbl_base;
            reg_last  = tbl_base + span;
        end else if (pick_fb1) begin
            reg_start = fb1_start;
            reg_last  = fb1_last;
        end else begin
            reg_start = fb0_start;
            reg_last  = fb0_last;
        end
    end
endmodule

// File: rtl/fseq_burst_len.sv
module fseq_burst_len #(
    parameter int AW = 32,
    parameter int LW = 5
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] last_addr,
    input  logic [LW-1:0] max_words,
    output logic [LW-1:0] len,
    output logic          final_burst
);
    localparam int WW = AW - 2;

    logic [WW-1:0] words_left;
    logic [WW-1:0] max_ext;

    always_comb begin
        words_left = last_addr[AW-1:2] - cur_addr[AW-1:2] + 1'b1;
        max_ext    = {{(WW-LW){1'b0}}, max_words};
        if (words_left <= max_ext) begin
            len         = words_left[LW-1:0];
            final_burst = 1'b1;
        end else begin
            len         = max_words;
            final_burst = 1'b0;
        end
    end
endmodule

// File: rtl/dfb_fetch_seq.sv
module dfb_fetch_seq
    import fseq_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scan_en,
    input  logic          dual_en,
    input  logic [2:0]    burst_code,
    input  logic [1:0]    load_mode,
    input  logic          tbl_8bpp,
    input  logic [AW-1:0] tbl_base,
    input  logic [AW-1:0] fb0_start,
    input  logic [AW-1:0] fb0_last,
    input  logic [AW-1:0] fb1_start,
    input  logic [AW-1:0] fb1_last,
    input  logic          mem_gnt,
    input  logic          pix_req,
    input  logic          fifo_empty,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [LW-1:0] mem_len,
    output logic          frame_done0,
    output logic          frame_done1,
    output logic          table_done,
    output logic          underflow
);
    phase_e        phase_q;
    logic [1:0]    mode_q;
    logic          cur_q, req_q;
    logic [AW-1:0] addr_q, last_q;
    logic [LW-1:0] bw_q, blen;
    logic          final_burst;
    logic          e0_q, e1_q, td_q, un_q;
    logic          pick_tbl, pick_fb1;
    logic [AW-1:0] nxt_start, nxt_last, step;
    logic [LW-1:0] nxt_bw;

    always_comb begin
        pick_tbl = (phase_q == PH_IDLE) && !load_mode[1];
        pick_fb1 = (phase_q == PH_PIX) && dual_en && !cur_q;
        step     = {{(AW-LW-2){1'b0}}, blen, 2'b00};
        nxt_bw   = LW'(burst_words(burst_code));
    end

    fseq_region_mux #(.AW(AW)) u_mux (
        .pick_tbl  (pick_tbl),
        .pick_fb1  (pick_fb1),
        .tbl_8bpp  (tbl_8bpp),
        .tbl_base  (tbl_base),
        .fb0_start (fb0_start),
        .fb0_last  (fb0_last),
        .fb1_start (fb1_start),
        .fb1_last  (fb1_last),
        .reg_start (nxt_start),
        .reg_last  (nxt_last)
    );

    fseq_burst_len #(.AW(AW), .LW(LW)) u_len (
        .cur_addr    (addr_q),
        .last_addr   (last_q),
        .max_words   (bw_q),
        .len         (blen),
        .final_burst (final_burst)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            mode_q  <= '0;
            cur_q   <= 1'b0;
            req_q   <= 1'b0;
            addr_q  <= '0;
            last_q  <= '0;
            bw_q    <= LW'(1);
            e0_q    <= 1'b0;
            e1_q    <= 1'b0;
            td_q    <= 1'b0;
            un_q    <= 1'b0;
        end else begin
            e0_q <= 1'b0;
            e1_q <= 1'b0;
            td_q <= 1'b0;
            un_q <= (phase_q == PH_PIX) && pix_req && fifo_empty;
            case (phase_q)
                PH_IDLE: begin
                    if (scan_en) begin
                        mode_q  <= load_mode;
                        cur_q   <= 1'b0;
                        addr_q  <= nxt_start;
                        last_q  <= nxt_last;
                        bw_q    <= nxt_bw;
                        phase_q <= load_mode[1] ? PH_PIX : PH_TBL;
                    end
                end
                PH_TBL, PH_PIX: begin
                    if (req_q) begin
                        if (mem_gnt) begin
                            req_q  <= 1'b0;
                            addr_q <= addr_q + step;
                            if (final_burst) begin
                                if (phase_q == PH_TBL) td_q <= 1'b1;
                                else if (cur_q)        e1_q <= 1'b1;
                                else                   e0_q <= 1'b1;
                                if (!scan_en) begin
                                    phase_q <= PH_IDLE;
                                end else if (phase_q == PH_TBL && mode_q == LM_TBL_ONLY) begin
                                    phase_q <= PH_HOLD;
                                end else begin
                                    phase_q <= PH_PIX;
                                    cur_q   <= pick_fb1;
                                    addr_q  <= nxt_start;
                                    last_q  <= nxt_last;
                                    bw_q    <= nxt_bw;
                                end
                            end else if (!scan_en) begin
                                phase_q <= PH_IDLE;
                            end
                        end
                    end else if (!scan_en) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        req_q <= 1'b1;
                    end
                end
                default: begin
                    if (!scan_en) phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    assign mem_req     = req_q;
    assign mem_addr    = addr_q;
    assign mem_len     = blen;
    assign frame_done0 = e0_q;
    assign frame_done1 = e1_q;
    assign table_done  = td_q;
    assign underflow   = un_q;
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
    parameter int AW = 32,
    parameter int LW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          scan_en,
    input logic          mem_gnt,
    input logic          pix_req,
    input logic          fifo_empty,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic [LW-1:0] mem_len,
    input logic          frame_done0,
    input logic          frame_done1,
    input logic          table_done,
    input logic          underflow
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_len)); // R2
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_len != '0) && (mem_len <= LW'(16))); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_done0, frame_done1, table_done})); // R4
    AST_DONE_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
        (frame_done0 || frame_done1 || table_done) |-> $past(mem_req && mem_gnt)); // R4
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !scan_en && !mem_req |=> !mem_req); // R9
    AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (rst)
        underflow |-> $past(pix_req && fifo_empty)); // R10
endmodule

bind dfb_fetch_seq fseq_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scan_en     (scan_en),
    .mem_gnt     (mem_gnt),
    .pix_req     (pix_req),
    .fifo_empty  (fifo_empty),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_len     (mem_len),
    .frame_done0 (frame_done0),
    .frame_done1 (frame_done1),
    .table_done  (table_done),
    .underflow   (underflow)
);

// File: tb/sim_dfb_fetch_seq.sv
`timescale 1ns/1ps
module sim_dfb_fetch_seq;
    localparam int AW = 32;
    localparam int LW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan_en = 0, dual_en = 0, tbl_8bpp = 0;
    logic [2:0] burst_code = 0;
    logic [1:0] load_mode = 0;
    logic [AW-1:0] tbl_base = 0, fb0_start = 0, fb0_last = 0, fb1_start = 0, fb1_last = 0;
    logic mem_gnt = 0, pix_req = 0, fifo_empty = 0;
    logic mem_req;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_len;
    logic frame_done0, frame_done1, table_done, underflow;

    always #10 clk = ~clk;

    dfb_fetch_seq #(.AW(AW), .LW(LW)) u0 (
        .clk(clk), .rst(rst), .scan_en(scan_en), .dual_en(dual_en),
        .burst_code(burst_code), .load_mode(load_mode), .tbl_8bpp(tbl_8bpp),
        .tbl_base(tbl_base), .fb0_start(fb0_start), .fb0_last(fb0_last),
        .fb1_start(fb1_start), .fb1_last(fb1_last), .mem_gnt(mem_gnt),
        .pix_req(pix_req), .fifo_empty(fifo_empty), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_len(mem_len), .frame_done0(frame_done0),
        .frame_done1(frame_done1), .table_done(table_done), .underflow(underflow)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit gnt_block = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference: 0 idle, 1 table, 2 pixels, 3 hold
    int m_ph, m_addr, m_last, m_bw, m_mode;
    bit m_req, m_cur, m_e0, m_e1, m_td, m_un;

    function automatic int words_of(input int code);
        if (code >= 4) return 16;
        return 1 << code;
    endfunction

    function automatic int m_len();
        int left;
        left = (m_last / 4) - (m_addr / 4) + 1;
        return (left < m_bw) ? left : m_bw;
    endfunction

    task automatic m_begin(input bit tbl, input bit second);
        if (tbl) begin
            m_addr = int'(tbl_base);
            m_last = int'(tbl_base) + (tbl_8bpp ? 511 : 31);
        end else begin
            m_addr = second ? int'(fb1_start) : int'(fb0_start);
            m_last = second ? int'(fb1_last) : int'(fb0_last);
        end
        m_bw = words_of(int'(burst_code));
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_req = 0; m_cur = 0; m_mode = 0;
            m_addr = 0; m_last = 0; m_bw = 1;
            m_e0 = 0; m_e1 = 0; m_td = 0; m_un = 0;
        end else begin
            m_e0 = 0; m_e1 = 0; m_td = 0;
            m_un = (m_ph == 2) && pix_req && fifo_empty;
            if (m_ph == 0) begin
                if (scan_en) begin
                    m_mode = int'(load_mode);
                    m_cur = 0;
                    m_begin(m_mode < 2, 0);
                    m_ph = (m_mode < 2) ? 1 : 2;
                end
            end else if (m_ph == 3) begin
                if (!scan_en) m_ph = 0;
            end else if (m_req) begin
                if (mem_gnt) begin
                    int l, left;
                    bit second;
                    l = m_len();
                    left = (m_last / 4) - (m_addr / 4) + 1;
                    m_req = 0;
                    m_addr = m_addr + 4 * l;
                    if (l == left) begin
                        if (m_ph == 1) m_td = 1;
                        else if (m_cur) m_e1 = 1;
                        else m_e0 = 1;
                        if (!scan_en) m_ph = 0;
                        else if (m_ph == 1 && m_mode == 1) m_ph = 3;
                        else begin
                            second = (m_ph == 2) && dual_en && !m_cur;
                            m_cur = second;
                            m_begin(0, second);
                            m_ph = 2;
                        end
                    end else if (!scan_en) m_ph = 0;
                end
            end else if (!scan_en) m_ph = 0;
            else m_req = 1;
        end
    end

    // observation counters
    int n_e0, n_e1, n_td, n_un, n_starts, held_len, first_addr, first_len, after_addr;
    int last_eof, alt_bad;
    bit prev_req, want_after;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk(mem_req == m_req, "R2 mem_req", int'(mem_req), int'(m_req));
            if (m_req && mem_req) begin
                chk(int'(mem_addr) == m_addr, "R3 mem_addr", int'(mem_addr), m_addr);
                chk(int'(mem_len) == m_len(), "R2 mem_len", int'(mem_len), m_len());
            end
            chk(frame_done0 == m_e0, "R4 frame_done0", int'(frame_done0), int'(m_e0));
            chk(frame_done1 == m_e1, "R4 frame_done1", int'(frame_done1), int'(m_e1));
            chk(table_done == m_td, "R5 table_done", int'(table_done), int'(m_td));
            chk(underflow == m_un, "R10 underflow", int'(underflow), int'(m_un));
            if (mem_req && !prev_req) begin
                if (n_starts == 0) begin first_addr = int'(mem_addr); first_len = int'(mem_len); end
                if (want_after) begin after_addr = int'(mem_addr); want_after = 0; end
                n_starts++;
            end
            if (mem_req) held_len = int'(mem_len);
            if (frame_done0) begin n_e0++; if (last_eof == 0) alt_bad++; last_eof = 0; want_after = 1; end
            if (frame_done1) begin n_e1++; if (last_eof == 1) alt_bad++; last_eof = 1; end
            if (table_done) n_td++;
            if (underflow) n_un++;
            prev_req = mem_req;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_gnt = gnt_block ? 1'b0 : (lfsr[3:2] != 2'b00);
        pix_req = lfsr[5];
        fifo_empty = lfsr[7] & lfsr[8];
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic do_reset();
        rst = 1; scan_en = 0; dual_en = 0; gnt_block = 0;
        step(3);
        n_e0 = 0; n_e1 = 0; n_td = 0; n_un = 0; n_starts = 0; held_len = 0;
        first_addr = -1; first_len = 0; after_addr = -1; last_eof = 1; alt_bad = 0;
        prev_req = 0; want_after = 0;
        rst = 0;
        step(1);
    endtask

    task automatic wait_e0(input int n);
        for (int i = 0; i < 5000 && n_e0 < n; i++) step(1);
    endtask

    initial begin
        do_reset();
        step(2);
        chk(mem_req == 0, "R1 mem_req after reset", int'(mem_req), 0);
        chk(frame_done0 == 0, "R1 frame_done0 after reset", int'(frame_done0), 0);
        chk(frame_done1 == 0, "R1 frame_done1 after reset", int'(frame_done1), 0);
        chk(table_done == 0, "R1 table_done after reset", int'(table_done), 0);
        chk(underflow == 0, "R1 underflow after reset", int'(underflow), 0);

        // pixels only, single region of 10 words, bursts of 4
        load_mode = 2; burst_code = 2; fb0_start = 32'h1000; fb0_last = 32'h1000 + 39;
        fb1_start = 32'h9000; fb1_last = 32'h9000 + 39; tbl_base = 32'h0400;
        do_reset(); scan_en = 1;
        wait_e0(3);
        chk(n_starts == 9, "R3 bursts over three 10-word passes", n_starts, 9);
        chk(held_len == 2, "R3 shortened final burst", held_len, 2);
        chk(n_e1 == 0, "R4 region 1 unused in single mode", n_e1, 0);
        chk(first_addr == 32'h1000, "R7 first request at region 0", first_addr, 32'h1000);
        chk(n_td == 0, "R7 no table phase", n_td, 0);
        chk(n_un > 0, "R10 underflow seen while fetching pixels", n_un, 1);

        // dual regions alternate
        dual_en = 1; burst_code = 3;
        fb0_start = 32'h2000; fb0_last = 32'h2000 + 47; fb1_start = 32'h3000; fb1_last = 32'h3000 + 19;
        do_reset(); dual_en = 1; scan_en = 1;
        for (int i = 0; i < 5000 && n_e1 < 2; i++) step(1);
        chk(n_e0 == 2, "R4 region 0 passes", n_e0, 2);
        chk(alt_bad == 0, "R4 alternation order", alt_bad, 0);
        chk(held_len == 5, "R3 region 1 single short burst", held_len, 5);

        // table then pixels, 16 entries
        load_mode = 0; burst_code = 4; tbl_8bpp = 0; fb0_start = 32'h1000; fb0_last = 32'h1000 + 39;
        do_reset(); scan_en = 1;
        for (int i = 0; i < 5000 && n_td < 1; i++) step(1);
        chk(first_addr == 32'h0400, "R5 table start address", first_addr, 32'h0400);
        chk(held_len == 8, "R5 16-entry table is 8 words", held_len, 8);
        wait_e0(1);
        chk(n_td == 1, "R5 single table_done", n_td, 1);

        // table then pixels, 256 entries
        tbl_8bpp = 1;
        do_reset(); scan_en = 1;
        for (int i = 0; i < 5000 && n_td < 1; i++) step(1);
        chk(n_starts == 8, "R5 256-entry table in 16-word bursts", n_starts, 8);
        wait_e0(1);

        // table only
        load_mode = 1; tbl_8bpp = 0;
        do_reset(); scan_en = 1;
        for (int i = 0; i < 5000 && n_td < 1; i++) step(1);
        begin
            int s;
            s = n_starts;
            step(60);
            chk(n_starts == s, "R6 no requests after table only", n_starts, s);
            chk(n_e0 == 0, "R6 no frame after table only", n_e0, 0);
            chk(n_un == 0, "R10 no underflow outside pixel phase", n_un, 0);
        end
        scan_en = 0; step(2);

        // address rewrite during a pass
        load_mode = 2; burst_code = 2; fb0_start = 32'h5000; fb0_last = 32'h5000 + 63;
        do_reset(); scan_en = 1;
        for (int i = 0; i < 5000 && n_starts < 1; i++) step(1);
        fb0_start = 32'h6000; fb0_last = 32'h6000 + 31;
        wait_e0(1);
        chk(n_starts == 4, "R8 running pass keeps old extent", n_starts, 4);
        for (int i = 0; i < 5000 && after_addr < 0; i++) step(1);
        chk(after_addr == 32'h6000, "R8 next pass uses new start", after_addr, 32'h6000);

        // disable with a request pending
        gnt_block = 1; step(2);
        for (int i = 0; i < 500 && !mem_req; i++) step(1);
        scan_en = 0;
        step(5);
        chk(mem_req == 1, "R9 pending request held", int'(mem_req), 1);
        begin
            int s;
            s = n_starts;
            gnt_block = 0;
            step(40);
            chk(mem_req == 0, "R9 idle after pending burst", int'(mem_req), 0);
            chk(n_starts == s, "R9 no new request", n_starts, s);
        end

        // burst codes
        burst_code = 0; fb0_start = 32'h7000; fb0_last = 32'h7000 + 11;
        do_reset(); scan_en = 1; wait_e0(1);
        chk(n_starts == 3, "R2 code 0 gives single words", n_starts, 3);
        burst_code = 1;
        do_reset(); scan_en = 1; wait_e0(1);
        chk(n_starts == 2, "R2 code 1 gives two words", n_starts, 2);
        chk(held_len == 1, "R3 tail of code 1", held_len, 1);
        burst_code = 5; fb0_last = 32'h7000 + 79;
        do_reset(); scan_en = 1; wait_e0(1);
        chk(first_len == 16, "R2 code 5 gives sixteen words", first_len, 16);
        chk(n_starts == 2, "R2 code 5 burst count", n_starts, 2);

        finish_run();
    end
endmodule